// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

In a multithreaded out-of-order core, this block chooses the hardware thread whose reorder-buffer head may retire in the current commit slot. Each thread gives it four things: a status code, a flag saying its head entry is ready, a flag saying its reorder buffer is empty, and the sequence number of its head entry. A configuration input selects one of three policies. The rotating policy keeps a priority list of thread indices. It walks that list and picks the first thread that qualifies. The age policy picks the qualifying thread with the oldest head. The greedy policy behaves exactly like the age policy, so a commit loop can query it several times in one cycle and get a consistent answer each time.

The result comes out as a valid/ready stream of one thread index. `grant_valid_o` and `grant_tid_o` are computed combinationally from the current inputs and the stored priority list. They never depend on `grant_ready_i`. The consumer holds `grant_ready_i` low to decline a grant. A grant is taken only in a cycle where valid and ready are both high. Under the rotating policy, a taken grant moves the winning thread to the tail of the list at the next clock edge. A declined grant changes nothing. The grant may change from cycle to cycle whenever the inputs change, because no grant is held waiting.

Top module: `commit_thread_sel`

## Requirements
- R1: `policy_i` is decoded as follows: 0 is greedy, 1 is rotating, 2 is age, and 3 is treated as age. Greedy and code 3 produce exactly the same grant as age for the same inputs.
- R2: Under the rotating policy, a thread qualifies when its status is Idle (code 0) or Running (code 1) and its head-ready bit is set. The empty flag is not considered. Status codes 2 (ROB squashing), 3 (trap pending) and 4 (fetch trap pending) never qualify.
- R3: Under the rotating policy, the grant goes to the first qualifying thread found when the priority list is walked from its head (entry 0) to its tail.
- R4: When a grant is taken (valid and ready both high) under the rotating policy, the granted thread moves to the tail of the list at the next clock edge. The other entries keep their relative order.
- R5: After reset the list holds threads 0 to N-1 in ascending order from the head. The list does not change in a cycle with no taken grant, and it does not change while the policy is not rotating.
- R6: Under the age policy, a thread qualifies when its reorder buffer is not empty, its head is ready, and its status is Idle, Running or fetch trap pending (code 4).
- R7: Under the age policy, the grant goes to the qualifying thread with the smallest head sequence number. When two threads tie on that number, the lower thread index wins.
- R8: When no thread qualifies, `grant_valid_o` is 0 and `grant_tid_o` is 0.
- R9: With a thread count of one, thread 0 is granted whenever its status is Idle, Running or fetch trap pending. This holds under every policy and regardless of the ready and empty flags.
- R10: The grant outputs do not depend on `grant_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Policy select (encoding in R1) |
| thr_state_i | input | 3*N | Per-thread status code; thread i occupies bits [3i+2:3i] |
| head_ready_i | input | N | Per-thread head-ready flag |
| rob_empty_i | input | N | Per-thread reorder-buffer-empty flag |
| head_seq_i | input | SEQ_W*N | Per-thread head sequence number; thread i occupies slice i |
| grant_ready_i | input | 1 | Consumer takes the offered grant |
| grant_valid_o | output | 1 | A thread is offered |
| grant_tid_o | output | max(1,clog2 N) | Offered thread index |

## Verification
Four areas get targeted checks, each one aimed at a specific mistake.

The first is list rotation. A full rotation cycle is run with some threads ineligible, and then the policy is switched back to rotating. A design that rotates the list by one place, or that drops the winner back at its old slot, would show the wrong winner on the following cycle. A design that rotates while a grant is declined, or while the age policy is active, would also be caught when the policy returns to rotating.

The second is eligibility. The age policy is driven with a thread in fetch-trap-pending status, and the rotating policy is driven with every buffer flagged empty. This catches a design that mixes up the two eligibility rules.

The third is age ordering. Tied sequence numbers and an empty thread holding the smallest number are both tested. Either one would expose a wrong comparison direction or missing tie handling.

The fourth is the single-thread configuration. It is checked with its head not ready, which catches a design that wrongly applies the multi-thread rules to it.

// File: rtl/ctsel_pkg.sv
package ctsel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_SQUASH = 3'd2,
    ST_TRAP   = 3'd3,
    ST_FTRAP  = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2,
    POL_SPARE  = 2'd3
  } pol_e;

  localparam int unsigned ST_W = 3;

  // status acceptable for the rotating policy
  function automatic logic rr_state_ok(input thr_state_e s);
    return (s == ST_IDLE) || (s == ST_RUN);
  endfunction

  // status acceptable for the age policy and single-thread mode
  function automatic logic age_state_ok(input thr_state_e s);
    return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_FTRAP);
  endfunction

endpackage

// File: rtl/ctsel_order.sv
module ctsel_order #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rotate,
  input  logic [TID_W-1:0]            rot_tid,
  output logic [N-1:0][TID_W-1:0]     order_o
);

  logic [N-1:0][TID_W-1:0] order_q, order_d;
  logic [N-1:0]            shift;

  // shift[i] is set for every slot at or behind the winner's slot
  always_comb begin
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      hit      = hit | (order_q[i] == rot_tid);
      shift[i] = hit;
    end
  end

  for (genvar i = 0; i < int'(N); i++) begin : g_slot
    if (i == int'(N) - 1) begin : g_tail
      assign order_d[i] = shift[i] ? rot_tid : order_q[i];
    end else begin : g_body
      assign order_d[i] = shift[i] ? order_q[i+1] : order_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N); i++) order_q[i] <= TID_W'(i);
    end else if (rotate) begin
      order_q <= order_d;
    end
  end

  assign order_o = order_q;

  // presence mask: every thread index appears exactly once
  logic [N-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < int'(N); i++)
      if (int'(order_q[i]) < int'(N)) present[order_q[i]] = 1'b1;
  end

  a_r4_list_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == N);

  a_r4_winner_to_tail: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> order_q[N-1] == $past(rot_tid));

  a_r5_hold_without_take: assert property (@(posedge clk) disable iff (!rst_n)
    !rotate |=> $stable(order_q));

endmodule

// File: rtl/ctsel_rr_pick.sv
module ctsel_rr_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic [N-1:0][TID_W-1:0] order_i,
  input  logic [N-1:0]            elig_i,
  output logic                    valid_o,
  output logic [TID_W-1:0]        tid_o
);

  // walk from head to tail, keep the first qualifying entry
  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (!valid_o && elig_i[order_i[i]]) begin
        valid_o = 1'b1;
        tid_o   = order_i[i];
      end
    end
  end

endmodule

// File: rtl/ctsel_age_pick.sv
module ctsel_age_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = 2,
  parameter int unsigned SEQ_W = 16
) (
  input  logic [N-1:0]            cand_i,
  input  logic [N-1:0][SEQ_W-1:0] seq_i,
  output logic                    valid_o,
  output logic [TID_W-1:0]        tid_o
);

  logic [SEQ_W-1:0] best_seq;

  // strict compare keeps the lower index on equal sequence numbers
  always_comb begin
    valid_o  = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (cand_i[i] && (!valid_o || seq_i[i] < best_seq)) begin
        valid_o  = 1'b1;
        tid_o    = TID_W'(i);
        best_seq = seq_i[i];
      end
    end
  end

endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel #(
  parameter int unsigned N     = 4,
  parameter int unsigned SEQ_W = 16,
  localparam int unsigned TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           policy_i,
  input  logic [N*3-1:0]       thr_state_i,
  input  logic [N-1:0]         head_ready_i,
  input  logic [N-1:0]         rob_empty_i,
  input  logic [N*SEQ_W-1:0]   head_seq_i,
  input  logic                 grant_ready_i,
  output logic                 grant_valid_o,
  output logic [TID_W-1:0]     grant_tid_o
);
  import ctsel_pkg::*;

  thr_state_e st [N];
  for (genvar i = 0; i < int'(N); i++) begin : g_unpack
    assign st[i] = thr_state_e'(thr_state_i[i*ST_W +: ST_W]);
  end

  if (N == 1) begin : g_single
    assign grant_valid_o = age_state_ok(st[0]);
    assign grant_tid_o   = '0;

    a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> (st[0] != ST_SQUASH && st[0] != ST_TRAP));

  end else begin : g_multi
    logic [N-1:0]            rr_elig, age_cand;
    logic [N-1:0][SEQ_W-1:0] seq_v;
    logic [N-1:0][TID_W-1:0] order;
    logic                    rr_v, age_v, use_rr, take;
    logic [TID_W-1:0]        rr_t, age_t;

    assign seq_v = head_seq_i;

    for (genvar i = 0; i < int'(N); i++) begin : g_elig
      assign rr_elig[i]  = head_ready_i[i] && rr_state_ok(st[i]);
      assign age_cand[i] = head_ready_i[i] && !rob_empty_i[i] && age_state_ok(st[i]);
    end

    assign use_rr = (pol_e'(policy_i) == POL_ROTATE);
    assign take   = use_rr && grant_valid_o && grant_ready_i;

    ctsel_order #(.N(N), .TID_W(TID_W)) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .rotate  (take),
      .rot_tid (grant_tid_o),
      .order_o (order)
    );

    ctsel_rr_pick #(.N(N), .TID_W(TID_W)) u_rr (
      .order_i (order),
      .elig_i  (rr_elig),
      .valid_o (rr_v),
      .tid_o   (rr_t)
    );

    ctsel_age_pick #(.N(N), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_age (
      .cand_i  (age_cand),
      .seq_i   (seq_v),
      .valid_o (age_v),
      .tid_o   (age_t)
    );

    assign grant_valid_o = use_rr ? rr_v : age_v;
    assign grant_tid_o   = use_rr ? rr_t : age_t;

    // no qualifying candidate beats the age winner
    logic [N-1:0] beats;
    for (genvar i = 0; i < int'(N); i++) begin : g_beats
      assign beats[i] = age_cand[i] &&
        ((seq_v[i] < seq_v[grant_tid_o]) ||
         (seq_v[i] == seq_v[grant_tid_o] && TID_W'(i) < grant_tid_o));
    end

    a_r2_rr_winner_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && use_rr) |->
        (head_ready_i[grant_tid_o] && rr_state_ok(st[grant_tid_o])));

    a_r6_age_winner_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && !use_rr) |->
        (head_ready_i[grant_tid_o] && !rob_empty_i[grant_tid_o] &&
         age_state_ok(st[grant_tid_o])));

    a_r7_age_is_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && !use_rr) |-> (beats == '0));

    a_r8_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid_o |-> (grant_tid_o == '0));

    a_r8_none_when_no_candidate: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_rr && age_cand == '0) |-> !grant_valid_o);
  end

endmodule

// File: tb/sim_commit_thread_sel.sv
module sim_commit_thread_sel;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // four-thread instance
  logic [1:0]  pol = 2'd1;
  logic [11:0] st = '0;
  logic [3:0]  rdy = '0, emp = '0;
  logic [63:0] seq = '0;
  logic        gready = 1'b0;
  logic        gv;
  logic [1:0]  gt;

  commit_thread_sel #(.N(4), .SEQ_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .thr_state_i(st),
    .head_ready_i(rdy), .rob_empty_i(emp), .head_seq_i(seq),
    .grant_ready_i(gready), .grant_valid_o(gv), .grant_tid_o(gt));

  // single-thread instance
  logic [1:0]  pol1 = 2'd1;
  logic [2:0]  st1 = '0;
  logic        rdy1 = 1'b0, emp1 = 1'b0, gready1 = 1'b0;
  logic [15:0] seq1 = '0;
  logic        gv1;
  logic [0:0]  gt1;

  commit_thread_sel #(.N(1), .SEQ_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .policy_i(pol1), .thr_state_i(st1),
    .head_ready_i(rdy1), .rob_empty_i(emp1), .head_seq_i(seq1),
    .grant_ready_i(gready1), .grant_valid_o(gv1), .grant_tid_o(gt1));

  int n_cmp = 0, n_bad = 0;
  int mlist [4];

  typedef struct { bit v; int t; string tag; } exp_t;
  exp_t sbq [$];
  event ev_cmp;

  // reference model built from the requirements
  function automatic void model(output bit v, output int t);
    bit age;
    int best;
    v = 0; t = 0;
    age = (pol != 2'd1);
    if (!age) begin
      for (int k = 0; k < 4; k++) begin
        int th = mlist[k];
        int s = st[th*3 +: 3];
        if (!v && rdy[th] && (s == 0 || s == 1)) begin v = 1; t = th; end
      end
    end else begin
      best = 0;
      for (int th = 0; th < 4; th++) begin
        int s = st[th*3 +: 3];
        int q = seq[th*16 +: 16];
        if (rdy[th] && !emp[th] && (s == 0 || s == 1 || s == 4) &&
            (!v || q < best)) begin
          v = 1; t = th; best = q;
        end
      end
    end
  endfunction

  task automatic drive(input bit [1:0] p, input bit [2:0] s0, s1, s2, s3,
                       input bit [3:0] r, e, input int q0, q1, q2, q3,
                       input bit gr, input string tag);
    exp_t x;
    bit v; int t;
    @(negedge clk);
    pol = p; st = {s3, s2, s1, s0}; rdy = r; emp = e;
    seq = {16'(q3), 16'(q2), 16'(q1), 16'(q0)}; gready = gr;
    model(v, t);
    x.v = v; x.t = t; x.tag = tag;
    sbq.push_back(x);
    #1 -> ev_cmp;
    if (v && gr && p == 2'd1) begin
      int pos = 0;
      for (int k = 0; k < 4; k++) if (mlist[k] == t) pos = k;
      for (int k = pos; k < 3; k++) mlist[k] = mlist[k+1];
      mlist[3] = t;
    end
  endtask

  // monitor: pops the scoreboard and compares against the ports
  initial begin
    forever begin
      @(ev_cmp);
      #1;
      if (sbq.size() != 0) begin
        exp_t x;
        x = sbq.pop_front();
        n_cmp++;
        if (gv !== x.v || gt !== x.t[1:0]) begin
          n_bad++;
          $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                   x.tag, gv, gt, x.v, x.t);
        end
      end
    end
  end

  task automatic check1(input bit [1:0] p, input bit [2:0] s, input bit r, e,
                        input bit ev, input string tag);
    @(negedge clk);
    pol1 = p; st1 = s; rdy1 = r; emp1 = e; gready1 = 1'b1;
    #2;
    n_cmp++;
    if (gv1 !== ev || gt1 !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=0",
               tag, gv1, gt1, ev);
    end
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam bit [2:0] I = 3'd0, R = 3'd1, S = 3'd2, T = 3'd3, F = 3'd4;

  initial begin
    for (int k = 0; k < 4; k++) mlist[k] = k;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R5 reset order, R3 head of list wins; declined grants keep the list (R10)
    drive(2'd1, R, R, R, R, 4'hF, 4'h0, 0, 0, 0, 0, 1'b0, "R5 reset order");
    drive(2'd1, R, R, R, R, 4'hF, 4'h0, 0, 0, 0, 0, 1'b0, "R10 declined grant");
    // R4 rotation across all threads
    for (int k = 0; k < 5; k++)
      drive(2'd1, R, I, R, I, 4'hF, 4'h0, 0, 0, 0, 0, 1'b1, "R4 rotation");
    // R2 squash/trap/fetch-trap excluded, empty ignored
    drive(2'd1, S, R, T, F, 4'hF, 4'hF, 0, 0, 0, 0, 1'b1, "R2 rr eligibility");
    drive(2'd1, R, S, R, F, 4'hD, 4'hF, 0, 0, 0, 0, 1'b1, "R3 skip unready");
    drive(2'd1, R, S, R, F, 4'hD, 4'h0, 0, 0, 0, 0, 1'b1, "R4 rotation skip");
    drive(2'd1, R, R, R, R, 4'hF, 4'h0, 0, 0, 0, 0, 1'b0, "R3 list order");
    // R8 nothing qualifies
    drive(2'd1, R, R, R, R, 4'h0, 4'h0, 0, 0, 0, 0, 1'b1, "R8 rr none");
    drive(2'd1, F, S, T, F, 4'hF, 4'h0, 0, 0, 0, 0, 1'b1, "R8 rr none by status");
    // R7 age order
    drive(2'd2, R, R, R, R, 4'hF, 4'h0, 40, 10, 30, 20, 1'b1, "R7 smallest seq");
    drive(2'd2, R, R, R, R, 4'hF, 4'h0, 9, 9, 3, 3, 1'b1, "R7 tie low index");
    // R6 empty/unready/status exclusion, fetch-trap accepted
    drive(2'd2, R, R, T, F, 4'hF, 4'h2, 50, 1, 2, 7, 1'b1, "R6 age eligibility");
    drive(2'd2, I, R, R, R, 4'h6, 4'h0, 1, 8, 5, 0, 1'b1, "R6 unready excluded");
    // R1 greedy and spare code mirror age
    drive(2'd0, R, R, R, R, 4'hF, 4'h0, 40, 10, 30, 20, 1'b1, "R1 greedy");
    drive(2'd0, R, R, T, F, 4'hF, 4'h2, 50, 1, 2, 7, 1'b1, "R1 greedy elig");
    drive(2'd3, R, R, R, R, 4'hF, 4'h0, 9, 9, 3, 3, 1'b1, "R1 spare code");
    drive(2'd2, S, T, R, R, 4'hF, 4'hC, 1, 2, 3, 4, 1'b1, "R8 age none");
    // R5 list untouched by takes under age policy
    drive(2'd1, R, R, R, R, 4'hF, 4'h0, 0, 0, 0, 0, 1'b0, "R5 no rotate in age");
    drive(2'd1, R, R, R, R, 4'hF, 4'h0, 0, 0, 0, 0, 1'b1, "R5 rr resumes");
    drive(2'd1, R, R, R, R, 4'hF, 4'h0, 0, 0, 0, 0, 1'b1, "R4 after resume");
    // R9 single-thread configuration
    check1(2'd1, I, 1'b0, 1'b1, 1'b1, "R9 single idle");
    check1(2'd2, R, 1'b0, 1'b1, 1'b1, "R9 single running");
    check1(2'd0, F, 1'b0, 1'b0, 1'b1, "R9 single fetch trap");
    check1(2'd1, S, 1'b1, 1'b0, 1'b0, "R9 single squashing");
    check1(2'd2, T, 1'b1, 1'b0, 1'b0, "R9 single trap");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule